// File: doc/BRIEF.md
# Exception and Interrupt Entry Sequencer

This block makes the state changes a processor needs when it enters an event handler. Five kinds of event can request entry: a memory-translation fault, a hardware exception, a hardware break, a software break and an external interrupt. From the current program counter, the status word, the pipeline flags (delay slot, immediate prefix, and whether the branch owning the delay slot was itself prefixed), the pending branch target and a vector base, the block works out several results. These are the handler address, the return-address register write, the new status word, the syndrome update, the branch-target capture, and a request to clear the pipeline flags.

When several requests are present in one cycle, only the one with the highest priority is served. The block registers every result, so the results appear for one cycle after the clock edge that samples the request. A three-bit event code names the event that was served. The pipeline uses this code to flush, and the core applies the write strobes to its architectural registers.

Top module: `exc_entry_seq`

## Requirements
- R1: An interrupt request is served only when status bit 0 (interrupt enable) is 1, status bit 4 (exception in progress) is 0, status bit 2 (break in progress) is 0, and both the delay-slot flag and the immediate-prefix flag are 0. Otherwise the request produces no entry.
- R2: Among simultaneous requests the served one is chosen in this order: fault first, then hardware exception, then hardware break, then software break, then interrupt. The event code reports the choice: 0 none, 1 fault, 2 hardware exception, 3 hardware break, 4 software break, 5 interrupt.
- R3: The new PC depends on the event. An interrupt gives base+0x10 and a hardware break gives base+0x18. A hardware exception or a fault gives base+0x20. A software break gives the pending branch target.
- R4: A hardware exception writes PC+4 into register 17.
- R5: An interrupt writes PC into register 14 and a hardware break writes PC into register 16. A software break writes no register.
- R6: A fault writes into register 17 a value derived from PC. The value is PC-4 in a delay slot and PC-8 in a delay slot whose branch was prefixed. It is PC-4 when only the immediate-prefix flag is set, and PC otherwise.
- R7: A hardware exception or a fault writes the syndrome input back with bit 12 equal to the delay-slot flag. The branch-target register is loaded with the pending target only when the delay-slot flag is set. Other events leave the syndrome unwritten.
- R8: On every entry, user mode (bit 8) and virtual mode (bit 10) move to their saved copies (bits 9 and 11), and bits 8 and 10 are then cleared.
- R9: In the new status word, a hardware exception or a fault sets bit 4, an interrupt clears bit 0, and either break sets bit 2. All bits not named in R8 and R9 keep their values.
- R10: When the exception feature is configured off (EXC_EN=0), a hardware exception request is ignored and the next lower pending request is served instead.
- R11: The flag-clear output pulses for a hardware exception or a fault, and for no other event.
- R12: Results appear on the clock edge after the request is sampled and last one cycle. While reset is held, every strobe is 0 and the event code is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pc_i | input | ADDR_W | Current program counter |
| status_i | input | 16 | Current status word |
| dslot_i | input | 1 | Current instruction is in a delay slot |
| imm_i | input | 1 | Current instruction follows an immediate prefix |
| bimm_i | input | 1 | Branch owning the delay slot was prefixed |
| btarget_i | input | ADDR_W | Pending branch target |
| vec_base_i | input | ADDR_W | Vector base address |
| syndrome_i | input | 16 | Current syndrome word |
| req_mmu_i | input | 1 | Translation fault request |
| req_hwexc_i | input | 1 | Hardware exception request |
| req_hwbrk_i | input | 1 | Hardware break request |
| req_swbrk_i | input | 1 | Software break request |
| req_irq_i | input | 1 | External interrupt request |
| taken_o | output | 3 | Served event code (R2 encoding) |
| pc_we_o | output | 1 | Load new PC |
| pc_o | output | ADDR_W | New PC |
| rf_we_o | output | 1 | Return-address register write |
| rf_idx_o | output | 5 | Return-address register index |
| rf_data_o | output | ADDR_W | Return address |
| status_we_o | output | 1 | Status write |
| status_o | output | 16 | New status word |
| syndrome_we_o | output | 1 | Syndrome write |
| syndrome_o | output | 16 | New syndrome word |
| btr_we_o | output | 1 | Branch-target register write |
| btr_o | output | ADDR_W | Captured branch target |
| flags_clr_o | output | 1 | Clear delay-slot and prefix flags |

## Verification
The hardest cases to reach are the fault return-address corrections, because each one needs a particular mix of delay-slot, prefix and branch-prefix flags. The case where the branch-prefix flag is set without the delay-slot flag is also hard to reach, and it must not change the address. The vector table walks each flag combination with a fault request, and each blocking condition with an interrupt request. It also stacks requests so that every level of the priority order is reached. A second instance built with the exception feature off shows the hardware exception dropping out and the break below it being served.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;

    localparam int ST_W   = 16;
    localparam int SYN_W  = 16;
    localparam int RIDX_W = 5;

    // status bit positions; each saved copy sits one bit above its mode bit
    localparam int ST_IE  = 0;
    localparam int ST_BIP = 2;
    localparam int ST_EIP = 4;
    localparam int ST_UM  = 8;
    localparam int ST_VM  = 10;
    localparam int SYN_DS = 12;

    localparam logic [ST_W-1:0] MODE_MASK = ST_W'((1 << ST_UM) | (1 << ST_VM));
    localparam logic [ST_W-1:0] SAVE_MASK = MODE_MASK << 1;

    localparam logic [RIDX_W-1:0] RET_EXC = RIDX_W'(17);
    localparam logic [RIDX_W-1:0] RET_IRQ = RIDX_W'(14);
    localparam logic [RIDX_W-1:0] RET_BRK = RIDX_W'(16);

    localparam int OFS_IRQ = 'h10;
    localparam int OFS_BRK = 'h18;
    localparam int OFS_EXC = 'h20;

    typedef enum logic [2:0] {
        EV_NONE  = 3'd0,
        EV_MMU   = 3'd1,
        EV_HWEXC = 3'd2,
        EV_HWBRK = 3'd3,
        EV_SWBRK = 3'd4,
        EV_IRQ   = 3'd5
    } ev_e;

    typedef struct packed {
        logic mmu;
        logic hwexc;
        logic hwbrk;
        logic swbrk;
        logic irq;
    } req_t;

    function automatic logic [ST_W-1:0] push_modes(input logic [ST_W-1:0] st);
        logic [ST_W-1:0] m;
        m = st & MODE_MASK;
        return (st & ~(MODE_MASK | SAVE_MASK)) | (m << 1);
    endfunction

endpackage

// File: rtl/exc_evt_arb.sv
module exc_evt_arb
    import exc_entry_pkg::*;
#(
    parameter bit EXC_EN = 1'b1
) (
    input  req_t            req,
    input  logic [ST_W-1:0] status,
    input  logic            dslot,
    input  logic            imm,
    output ev_e             ev
);
    logic hwexc_ok;
    logic irq_ok;

    generate
        if (EXC_EN) begin : g_exc
            assign hwexc_ok = req.hwexc;
        end else begin : g_noexc
            assign hwexc_ok = 1'b0;
        end
    endgenerate

    assign irq_ok = req.irq && status[ST_IE] && !status[ST_EIP] &&
                    !status[ST_BIP] && !dslot && !imm;

    always_comb begin
        if (req.mmu)        ev = EV_MMU;
        else if (hwexc_ok)  ev = EV_HWEXC;
        else if (req.hwbrk) ev = EV_HWBRK;
        else if (req.swbrk) ev = EV_SWBRK;
        else if (irq_ok)    ev = EV_IRQ;
        else                ev = EV_NONE;
    end
endmodule

// File: rtl/exc_ret_calc.sv
module exc_ret_calc
    import exc_entry_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  ev_e               ev,
    input  logic [ADDR_W-1:0] pc,
    input  logic              dslot,
    input  logic              imm,
    input  logic              bimm,
    output logic              rf_we,
    output logic [RIDX_W-1:0] rf_idx,
    output logic [ADDR_W-1:0] rf_data
);
    localparam logic [ADDR_W-1:0] STEP = ADDR_W'(4);

    logic [ADDR_W-1:0] back;

    always_comb begin
        if (dslot)    back = bimm ? (STEP << 1) : STEP;
        else if (imm) back = STEP;
        else          back = '0;
    end

    always_comb begin
        rf_we   = 1'b0;
        rf_idx  = '0;
        rf_data = pc;
        case (ev)
            EV_HWEXC: begin rf_we = 1'b1; rf_idx = RET_EXC; rf_data = pc + STEP; end
            EV_MMU:   begin rf_we = 1'b1; rf_idx = RET_EXC; rf_data = pc - back; end
            EV_IRQ:   begin rf_we = 1'b1; rf_idx = RET_IRQ; end
            EV_HWBRK: begin rf_we = 1'b1; rf_idx = RET_BRK; end
            default:  ;
        endcase
    end
endmodule

// File: rtl/exc_state_upd.sv
module exc_state_upd
    import exc_entry_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  ev_e               ev,
    input  logic [ST_W-1:0]   status,
    input  logic [SYN_W-1:0]  syndrome,
    input  logic              dslot,
    input  logic [ADDR_W-1:0] btarget,
    input  logic [ADDR_W-1:0] vec_base,
    output logic [ADDR_W-1:0] pc_n,
    output logic [ST_W-1:0]   status_n,
    output logic              syn_we,
    output logic [SYN_W-1:0]  syn_n,
    output logic              btr_we,
    output logic              flags_clr
);
    logic exc_like;

    assign exc_like = (ev == EV_HWEXC) || (ev == EV_MMU);

    always_comb begin
        status_n = push_modes(status);
        pc_n     = vec_base + ADDR_W'(OFS_EXC);
        case (ev)
            EV_IRQ: begin
                status_n[ST_IE] = 1'b0;
                pc_n = vec_base + ADDR_W'(OFS_IRQ);
            end
            EV_HWBRK: begin
                status_n[ST_BIP] = 1'b1;
                pc_n = vec_base + ADDR_W'(OFS_BRK);
            end
            EV_SWBRK: begin
                status_n[ST_BIP] = 1'b1;
                pc_n = btarget;
            end
            default: status_n[ST_EIP] = 1'b1;
        endcase
    end

    always_comb begin
        syn_n         = syndrome;
        syn_n[SYN_DS] = dslot;
    end

    assign syn_we    = exc_like;
    assign btr_we    = exc_like && dslot;
    assign flags_clr = exc_like;
endmodule

// File: rtl/exc_entry_seq.sv
module exc_entry_seq
    import exc_entry_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter bit EXC_EN = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] pc_i,
    input  logic [ST_W-1:0]   status_i,
    input  logic              dslot_i,
    input  logic              imm_i,
    input  logic              bimm_i,
    input  logic [ADDR_W-1:0] btarget_i,
    input  logic [ADDR_W-1:0] vec_base_i,
    input  logic [SYN_W-1:0]  syndrome_i,
    input  logic              req_mmu_i,
    input  logic              req_hwexc_i,
    input  logic              req_hwbrk_i,
    input  logic              req_swbrk_i,
    input  logic              req_irq_i,
    output logic [2:0]        taken_o,
    output logic              pc_we_o,
    output logic [ADDR_W-1:0] pc_o,
    output logic              rf_we_o,
    output logic [RIDX_W-1:0] rf_idx_o,
    output logic [ADDR_W-1:0] rf_data_o,
    output logic              status_we_o,
    output logic [ST_W-1:0]   status_o,
    output logic              syndrome_we_o,
    output logic [SYN_W-1:0]  syndrome_o,
    output logic              btr_we_o,
    output logic [ADDR_W-1:0] btr_o,
    output logic              flags_clr_o
);
    req_t              req;
    ev_e               ev, ev_q;
    logic              rf_we_n, syn_we_n, btr_we_n, clr_n;
    logic [RIDX_W-1:0] idx_n;
    logic [ADDR_W-1:0] ret_n, pc_n;
    logic [ST_W-1:0]   st_n;
    logic [SYN_W-1:0]  syn_n;

    assign req = '{mmu: req_mmu_i, hwexc: req_hwexc_i, hwbrk: req_hwbrk_i,
                   swbrk: req_swbrk_i, irq: req_irq_i};

    exc_evt_arb #(.EXC_EN(EXC_EN)) u_arb (
        .req(req), .status(status_i), .dslot(dslot_i), .imm(imm_i), .ev(ev)
    );

    exc_ret_calc #(.ADDR_W(ADDR_W)) u_ret (
        .ev(ev), .pc(pc_i), .dslot(dslot_i), .imm(imm_i), .bimm(bimm_i),
        .rf_we(rf_we_n), .rf_idx(idx_n), .rf_data(ret_n)
    );

    exc_state_upd #(.ADDR_W(ADDR_W)) u_upd (
        .ev(ev), .status(status_i), .syndrome(syndrome_i), .dslot(dslot_i),
        .btarget(btarget_i), .vec_base(vec_base_i), .pc_n(pc_n),
        .status_n(st_n), .syn_we(syn_we_n), .syn_n(syn_n),
        .btr_we(btr_we_n), .flags_clr(clr_n)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ev_q          <= EV_NONE;
            pc_we_o       <= 1'b0;
            rf_we_o       <= 1'b0;
            status_we_o   <= 1'b0;
            syndrome_we_o <= 1'b0;
            btr_we_o      <= 1'b0;
            flags_clr_o   <= 1'b0;
            pc_o          <= '0;
            rf_idx_o      <= '0;
            rf_data_o     <= '0;
            status_o      <= '0;
            syndrome_o    <= '0;
            btr_o         <= '0;
        end else begin
            ev_q          <= ev;
            pc_we_o       <= (ev != EV_NONE);
            rf_we_o       <= rf_we_n;
            status_we_o   <= (ev != EV_NONE);
            syndrome_we_o <= syn_we_n;
            btr_we_o      <= btr_we_n;
            flags_clr_o   <= clr_n;
            pc_o          <= pc_n;
            rf_idx_o      <= idx_n;
            rf_data_o     <= ret_n;
            status_o      <= st_n;
            syndrome_o    <= syn_n;
            btr_o         <= btarget_i;
        end
    end

    assign taken_o = ev_q;

    // R1
    irq_gate_chk: assert property (@(posedge clk) disable iff (rst)
        (ev_q == EV_IRQ) |-> ($past(status_i[ST_IE]) && !$past(status_i[ST_EIP]) &&
                              !$past(status_i[ST_BIP]) && !$past(dslot_i) && !$past(imm_i)));

    // R2
    irq_lowest_chk: assert property (@(posedge clk) disable iff (rst)
        (ev_q == EV_IRQ) |-> (!$past(req_mmu_i) && !$past(req_hwbrk_i) && !$past(req_swbrk_i)));

    // R3
    brk_vector_chk: assert property (@(posedge clk) disable iff (rst)
        (ev_q == EV_HWBRK) |-> (pc_o == $past(vec_base_i) + ADDR_W'(OFS_BRK)));

    // R7
    btr_capture_chk: assert property (@(posedge clk) disable iff (rst)
        btr_we_o |-> (btr_o == $past(btarget_i) && syndrome_o[SYN_DS] && syndrome_we_o));

    // R8
    mode_cleared_chk: assert property (@(posedge clk) disable iff (rst)
        status_we_o |-> (!status_o[ST_UM] && !status_o[ST_VM]));

    // R11
    flag_clear_chk: assert property (@(posedge clk) disable iff (rst)
        flags_clr_o |-> (ev_q == EV_MMU || ev_q == EV_HWEXC));
endmodule

// File: tb/exc_entry_seq_test.sv
`timescale 1ns/1ps
module exc_entry_seq_test;
    import exc_entry_pkg::*;

    localparam int AW = 32;
    localparam logic [AW-1:0] PC   = 32'h0000_1000;
    localparam logic [AW-1:0] BT   = 32'h0000_2400;
    localparam logic [AW-1:0] BASE = 32'h0000_8000;

    typedef struct packed {
        logic [4:0]  req;   // {mmu, hwexc, hwbrk, swbrk, irq}
        logic        ds;
        logic        im;
        logic        bi;
        logic [15:0] st;
        logic [2:0]  ev;
        logic [31:0] npc;
        logic        rfwe;
        logic [4:0]  idx;
        logic [31:0] rdata;
        logic [15:0] nst;
    } vec_t;

    localparam int NV = 21;
    localparam vec_t VECS [NV] = '{
        '{5'b00001, 1'b0, 1'b0, 1'b0, 16'h0501, 3'd5, 32'h8010, 1'b1, 5'd14, 32'h1000, 16'h0A00},
        '{5'b00001, 1'b0, 1'b0, 1'b0, 16'h0500, 3'd0, 32'h0,    1'b0, 5'd0,  32'h0,    16'h0},
        '{5'b00001, 1'b1, 1'b0, 1'b0, 16'h0501, 3'd0, 32'h0,    1'b0, 5'd0,  32'h0,    16'h0},
        '{5'b00001, 1'b0, 1'b1, 1'b0, 16'h0501, 3'd0, 32'h0,    1'b0, 5'd0,  32'h0,    16'h0},
        '{5'b00001, 1'b0, 1'b0, 1'b0, 16'h0511, 3'd0, 32'h0,    1'b0, 5'd0,  32'h0,    16'h0},
        '{5'b00001, 1'b0, 1'b0, 1'b0, 16'h0505, 3'd0, 32'h0,    1'b0, 5'd0,  32'h0,    16'h0},
        '{5'b01000, 1'b0, 1'b0, 1'b0, 16'h0501, 3'd2, 32'h8020, 1'b1, 5'd17, 32'h1004, 16'h0A11},
        '{5'b01000, 1'b1, 1'b0, 1'b1, 16'h0501, 3'd2, 32'h8020, 1'b1, 5'd17, 32'h1004, 16'h0A11},
        '{5'b10000, 1'b0, 1'b0, 1'b0, 16'h0501, 3'd1, 32'h8020, 1'b1, 5'd17, 32'h1000, 16'h0A11},
        '{5'b10000, 1'b1, 1'b0, 1'b0, 16'h0501, 3'd1, 32'h8020, 1'b1, 5'd17, 32'h0FFC, 16'h0A11},
        '{5'b10000, 1'b1, 1'b0, 1'b1, 16'h0501, 3'd1, 32'h8020, 1'b1, 5'd17, 32'h0FF8, 16'h0A11},
        '{5'b10000, 1'b0, 1'b1, 1'b0, 16'h0501, 3'd1, 32'h8020, 1'b1, 5'd17, 32'h0FFC, 16'h0A11},
        '{5'b10000, 1'b0, 1'b0, 1'b1, 16'h0501, 3'd1, 32'h8020, 1'b1, 5'd17, 32'h1000, 16'h0A11},
        '{5'b00100, 1'b0, 1'b0, 1'b0, 16'h0501, 3'd3, 32'h8018, 1'b1, 5'd16, 32'h1000, 16'h0A05},
        '{5'b00010, 1'b0, 1'b0, 1'b0, 16'h0501, 3'd4, 32'h2400, 1'b0, 5'd0,  32'h0,    16'h0A05},
        '{5'b11111, 1'b0, 1'b0, 1'b0, 16'h0501, 3'd1, 32'h8020, 1'b1, 5'd17, 32'h1000, 16'h0A11},
        '{5'b01111, 1'b0, 1'b0, 1'b0, 16'h0501, 3'd2, 32'h8020, 1'b1, 5'd17, 32'h1004, 16'h0A11},
        '{5'b00111, 1'b0, 1'b0, 1'b0, 16'h0501, 3'd3, 32'h8018, 1'b1, 5'd16, 32'h1000, 16'h0A05},
        '{5'b00011, 1'b0, 1'b0, 1'b0, 16'h0501, 3'd4, 32'h2400, 1'b0, 5'd0,  32'h0,    16'h0A05},
        '{5'b00100, 1'b0, 1'b0, 1'b0, 16'h0001, 3'd3, 32'h8018, 1'b1, 5'd16, 32'h1000, 16'h0005},
        '{5'b00001, 1'b0, 1'b0, 1'b0, 16'h0A01, 3'd5, 32'h8010, 1'b1, 5'd14, 32'h1000, 16'h0000}
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2.5 clk = ~clk;

    logic [AW-1:0] pc_i = PC, btarget_i = BT, vec_base_i = BASE;
    logic [15:0]   status_i = '0, syndrome_i = '0;
    logic dslot_i = 0, imm_i = 0, bimm_i = 0;
    logic req_mmu_i = 0, req_hwexc_i = 0, req_hwbrk_i = 0, req_swbrk_i = 0, req_irq_i = 0;

    logic [2:0] taken_o;
    logic pc_we_o, rf_we_o, status_we_o, syndrome_we_o, btr_we_o, flags_clr_o;
    logic [AW-1:0] pc_o, rf_data_o, btr_o;
    logic [4:0] rf_idx_o;
    logic [15:0] status_o, syndrome_o;

    logic [2:0] nx_taken;
    logic nx_pc_we, nx_rf_we, nx_st_we, nx_syn_we, nx_btr_we, nx_clr;
    logic [AW-1:0] nx_pc, nx_rdata, nx_btr;
    logic [4:0] nx_idx;
    logic [15:0] nx_st, nx_syn;

    exc_entry_seq #(.ADDR_W(AW), .EXC_EN(1'b1)) uut (
        .clk, .rst, .pc_i, .status_i, .dslot_i, .imm_i, .bimm_i, .btarget_i,
        .vec_base_i, .syndrome_i, .req_mmu_i, .req_hwexc_i, .req_hwbrk_i,
        .req_swbrk_i, .req_irq_i, .taken_o, .pc_we_o, .pc_o, .rf_we_o,
        .rf_idx_o, .rf_data_o, .status_we_o, .status_o, .syndrome_we_o,
        .syndrome_o, .btr_we_o, .btr_o, .flags_clr_o
    );

    exc_entry_seq #(.ADDR_W(AW), .EXC_EN(1'b0)) uut_noexc (
        .clk, .rst, .pc_i, .status_i, .dslot_i, .imm_i, .bimm_i, .btarget_i,
        .vec_base_i, .syndrome_i, .req_mmu_i, .req_hwexc_i, .req_hwbrk_i,
        .req_swbrk_i, .req_irq_i, .taken_o(nx_taken), .pc_we_o(nx_pc_we),
        .pc_o(nx_pc), .rf_we_o(nx_rf_we), .rf_idx_o(nx_idx), .rf_data_o(nx_rdata),
        .status_we_o(nx_st_we), .status_o(nx_st), .syndrome_we_o(nx_syn_we),
        .syndrome_o(nx_syn), .btr_we_o(nx_btr_we), .btr_o(nx_btr), .flags_clr_o(nx_clr)
    );

    int checks = 0;
    int errors = 0;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic set_req(input logic [4:0] r);
        {req_mmu_i, req_hwexc_i, req_hwbrk_i, req_swbrk_i, req_irq_i} = r;
    endtask

    // drive at falling edge, let one rising edge register, sample at next falling edge
    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        #1ms;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        @(negedge clk);
        set_req(5'b11111);
        step();
        // R12 reset holds every strobe low
        check("R12 reset taken", 32'(taken_o), 32'd0);
        check("R12 reset strobes", 32'({pc_we_o, rf_we_o, status_we_o, syndrome_we_o, btr_we_o, flags_clr_o}), 32'd0);
        set_req(5'b0);
        rst = 1'b0;
        step();

        for (int i = 0; i < NV; i++) begin
            set_req(VECS[i].req);
            dslot_i = VECS[i].ds; imm_i = VECS[i].im; bimm_i = VECS[i].bi;
            status_i = VECS[i].st;
            step();
            check($sformatf("R1 R2 vec%0d taken", i), 32'(taken_o), 32'(VECS[i].ev));
            if (VECS[i].ev != 3'd0) begin
                check($sformatf("R3 vec%0d pc", i), pc_o, VECS[i].npc);
                check($sformatf("R5 vec%0d rf_we", i), 32'(rf_we_o), 32'(VECS[i].rfwe));
                if (VECS[i].rfwe) begin
                    check($sformatf("R4 R5 R6 vec%0d idx", i), 32'(rf_idx_o), 32'(VECS[i].idx));
                    check($sformatf("R4 R5 R6 vec%0d data", i), rf_data_o, VECS[i].rdata);
                end
                check($sformatf("R8 R9 vec%0d status", i), 32'(status_o), 32'(VECS[i].nst));
            end else begin
                check($sformatf("R1 vec%0d no write", i), 32'({pc_we_o, rf_we_o, status_we_o}), 32'd0);
            end
            set_req(5'b0);
            step();
            // R12 single-cycle result
            check($sformatf("R12 vec%0d pulse", i), 32'(taken_o), 32'd0);
        end

        // R7 bit 12 cleared outside a delay slot, no branch-target capture
        status_i = 16'h0501; dslot_i = 0; imm_i = 0; bimm_i = 0;
        syndrome_i = 16'h10FF; set_req(5'b01000);
        step();
        check("R7 syn we", 32'(syndrome_we_o), 32'd1);
        check("R7 syn clear", 32'(syndrome_o), 32'h00FF);
        check("R7 no btr", 32'(btr_we_o), 32'd0);
        check("R11 clr hwexc", 32'(flags_clr_o), 32'd1);

        // R7 delay slot on a fault sets bit 12 and captures target
        syndrome_i = 16'h00FF; dslot_i = 1; set_req(5'b10000);
        step();
        check("R7 syn set", 32'(syndrome_o), 32'h10FF);
        check("R7 btr we", 32'(btr_we_o), 32'd1);
        check("R7 btr val", btr_o, BT);
        check("R11 clr mmu", 32'(flags_clr_o), 32'd1);

        // R7 R11 interrupt and break touch neither syndrome nor flags
        dslot_i = 0; set_req(5'b00001);
        step();
        check("R7 irq no syn", 32'({syndrome_we_o, btr_we_o}), 32'd0);
        check("R11 irq no clr", 32'(flags_clr_o), 32'd0);
        set_req(5'b00100);
        step();
        check("R11 hwbrk no clr", 32'(flags_clr_o), 32'd0);

        // R10 exception feature off
        set_req(5'b01000);
        step();
        check("R10 hwexc ignored", 32'(nx_taken), 32'd0);
        check("R10 no pc write", 32'(nx_pc_we), 32'd0);
        check("R10 enabled serves", 32'(taken_o), 32'd2);
        set_req(5'b01100);
        step();
        check("R10 falls to hwbrk", 32'(nx_taken), 32'd3);
        check("R10 hwbrk pc", nx_pc, BASE + 32'h18);

        // R12 reset with requests pending
        set_req(5'b11111); rst = 1'b1;
        step();
        check("R12 reset with req", 32'({taken_o, pc_we_o, rf_we_o, status_we_o}), 32'd0);
        rst = 1'b0; set_req(5'b0);
        step();

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule